// File: doc/BRIEF.md
# Bus-Readable 64-bit Cycle Meter

This peripheral measures how many clock cycles a piece of host software takes. Software writes a start command to the control word just before the code under test and a stop command just after it. In between, a 64-bit counter advances once per clock. Software then reads the result as two 32-bit words over an AXI4-Lite slave port, which uses all five channels.

Reading the low word also captures the upper half of the counter into a shadow register. A following read of the high word therefore returns an upper half that matches the low half already read, even though the counter kept running between the two reads. Starting from a stopped state clears the counter. A stop command freezes it. When one write carries both commands, the stop command wins.

Top module: `cycle_meter_axil`

## Requirements
- R1: While running, the count rises by exactly one on every clock edge and wraps from 2^64-1 to 0. While stopped, it keeps its value.
- R2: A control write with bit 0 set, bit 1 clear, and bit 0 of the previously stored control word clear sets the count to zero and starts counting. If the stored bit 0 was already set, the count is neither cleared nor changed in run state.
- R3: A control write with bit 1 set stops counting. The edge carrying the write still counts if the meter was running, and the count then stays frozen.
- R4: A control write with both bit 0 and bit 1 set stops counting and does not clear the count.
- R5: The control word sits at byte offset 0x0. Reads return the last written bits 1:0, with zeros above them. A write whose byte-strobe bit 0 is low leaves it unchanged.
- R6: Offset 0x4 returns count bits 31:0 as they were at the read-address handshake, and captures count bits 63:32 in that same cycle. Offset 0x8 returns that captured value, which is zero after reset.
- R7: Writes to 0x4, 0x8 or any unmapped offset have no effect. Unmapped offsets read as zero. Every response is OKAY (0).
- R8: Write address and write data are accepted in either order. BVALID rises on the second clock edge after the later of the two handshakes, and both ready signals stay low while BVALID is high. A control write takes effect on the edge that raises BVALID.
- R9: BVALID stays high until BREADY is high. RVALID and RDATA stay high and unchanged until RREADY is high.
- R10: After reset, the counter is stopped and reads as zero, the control word is zero, and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| awAddr | input | ADDR_W | Write address |
| awValid | input | 1 | Write address valid |
| awReady | output | 1 | Write address ready |
| wData | input | DATA_W | Write data |
| wStrb | input | DATA_W/8 | Write byte strobes |
| wValid | input | 1 | Write data valid |
| wReady | output | 1 | Write data ready |
| bResp | output | 2 | Write response, always OKAY |
| bValid | output | 1 | Write response valid |
| bReady | input | 1 | Write response ready |
| arAddr | input | ADDR_W | Read address |
| arValid | input | 1 | Read address valid |
| arReady | output | 1 | Read address ready |
| rData | output | DATA_W | Read data |
| rResp | output | 2 | Read response, always OKAY |
| rValid | output | 1 | Read data valid |
| rReady | input | 1 | Read data ready |

## Verification
The bench applies sequences of control writes and checks each one against a behavioural model that advances every clock. The sequences are:

- a fresh start from the stopped state, which tells a real clear apart from simple resumption;
- a repeated start with bit 0 already set, which must not clear;
- a stop, after which two reads must return the same frozen value;
- a combined start-and-stop write, which must neither run nor clear.

Write handshakes are issued with address and data together, with data late, and with address late. Response back-pressure is held for several cycles on both channels. Writes to read-only, unmapped and strobe-masked locations are each followed by reads that would expose a change.

// File: rtl/cyc_pkg.sv
package cyc_pkg;
  // Word indices of the mapped locations (byte offset / 4).
  localparam int CTRL_IDX = 0;
  localparam int LOW_IDX  = 1;
  localparam int HIGH_IDX = 2;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  // Strobes passed from the bus control into the counter datapath.
  typedef struct packed {
    logic       wrCtrl;   // control word written this cycle
    logic [1:0] wrBits;   // {stop, start} as written
    logic       rdLow;    // low word read: capture upper half
  } cyc_strobe_t;
endpackage

// File: rtl/cyc_counter_core.sv
module cyc_counter_core
  import cyc_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  cyc_strobe_t       str,
  output logic [1:0]        ctrlBits,
  output logic [DATA_W-1:0] cntLow,
  output logic [DATA_W-1:0] cntHighShadow
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [1:0]       ctrlQ;
  logic             running;
  logic [CNT_W-1:0] cnt;
  logic [HI_W-1:0]  shadowQ;
  logic             stopReq;
  logic             startRise;

  assign stopReq   = str.wrCtrl && str.wrBits[1];
  assign startRise = str.wrCtrl && str.wrBits[0] && !str.wrBits[1] && !ctrlQ[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      running <= 1'b0;
      cnt     <= '0;
      shadowQ <= '0;
    end else begin
      if (str.wrCtrl) ctrlQ <= str.wrBits;
      if (stopReq)        running <= 1'b0;
      else if (startRise) running <= 1'b1;
      if (startRise)    cnt <= '0;
      else if (running) cnt <= cnt + 1'b1;
      if (str.rdLow) shadowQ <= cnt[CNT_W-1:DATA_W];
    end
  end

  assign ctrlBits = ctrlQ;
  assign cntLow   = cnt[DATA_W-1:0];

  generate
    if (HI_W < DATA_W) begin : g_pad
      assign cntHighShadow = {{(DATA_W-HI_W){1'b0}}, shadowQ};
    end else begin : g_full
      assign cntHighShadow = shadowQ[DATA_W-1:0];
    end
  endgenerate

  // R1: increments by one when running (wrap is natural modulo 2^CNT_W)
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    running && !startRise |=> cnt == $past(cnt) + 1'b1);
  // R1: holds when stopped
  assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !running && !startRise |=> $stable(cnt));
  // R2: fresh start clears and runs
  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    startRise |=> cnt == '0 && running);
  // R4: stop wins over start
  assert_stop_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    str.wrCtrl && str.wrBits == 2'b11 |=> !running);
endmodule

// File: rtl/cyc_axil_ctrl.sv
module cyc_axil_ctrl
  import cyc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   awAddr,
  input  logic                awValid,
  output logic                awReady,
  input  logic [DATA_W-1:0]   wData,
  input  logic [DATA_W/8-1:0] wStrb,
  input  logic                wValid,
  output logic                wReady,
  output logic [1:0]          bResp,
  output logic                bValid,
  input  logic                bReady,
  input  logic [ADDR_W-1:0]   arAddr,
  input  logic                arValid,
  output logic                arReady,
  output logic [DATA_W-1:0]   rData,
  output logic [1:0]          rResp,
  output logic                rValid,
  input  logic                rReady,
  input  logic [1:0]          ctrlBits,
  input  logic [DATA_W-1:0]   cntLow,
  input  logic [DATA_W-1:0]   cntHighShadow,
  output cyc_strobe_t         str
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] I_CTRL = IDX_W'(CTRL_IDX);
  localparam logic [IDX_W-1:0] I_LOW  = IDX_W'(LOW_IDX);
  localparam logic [IDX_W-1:0] I_HIGH = IDX_W'(HIGH_IDX);

  // ---- write side ----
  logic                awHave, wHave, bValidQ;
  logic [IDX_W-1:0]    awIdxQ;
  logic [1:0]          wBitsQ;
  logic                wStrb0Q;
  logic                doWrite;

  assign awReady = !awHave && !bValidQ;
  assign wReady  = !wHave && !bValidQ;
  assign doWrite = awHave && wHave && !bValidQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      awHave  <= 1'b0;
      wHave   <= 1'b0;
      bValidQ <= 1'b0;
      awIdxQ  <= '0;
      wBitsQ  <= '0;
      wStrb0Q <= 1'b0;
    end else begin
      if (awValid && awReady) begin
        awHave <= 1'b1;
        awIdxQ <= awAddr[ADDR_W-1:2];
      end
      if (wValid && wReady) begin
        wHave   <= 1'b1;
        wBitsQ  <= wData[1:0];
        wStrb0Q <= wStrb[0];
      end
      if (doWrite) begin
        awHave  <= 1'b0;
        wHave   <= 1'b0;
        bValidQ <= 1'b1;
      end else if (bValidQ && bReady) begin
        bValidQ <= 1'b0;
      end
    end
  end

  assign bValid = bValidQ;
  assign bResp  = RESP_OKAY;

  // ---- read side ----
  logic              rValidQ;
  logic [DATA_W-1:0] rDataQ;
  logic [DATA_W-1:0] rdMux;
  logic              arHs;
  logic [IDX_W-1:0]  arIdx;

  assign arReady = !rValidQ;
  assign arHs    = arValid && arReady;
  assign arIdx   = arAddr[ADDR_W-1:2];

  always_comb begin
    case (arIdx)
      I_CTRL:  rdMux = {{(DATA_W-2){1'b0}}, ctrlBits};
      I_LOW:   rdMux = cntLow;
      I_HIGH:  rdMux = cntHighShadow;
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rValidQ <= 1'b0;
      rDataQ  <= '0;
    end else if (arHs) begin
      rValidQ <= 1'b1;
      rDataQ  <= rdMux;
    end else if (rValidQ && rReady) begin
      rValidQ <= 1'b0;
    end
  end

  assign rValid = rValidQ;
  assign rData  = rDataQ;
  assign rResp  = RESP_OKAY;

  // ---- strobes to datapath ----
  assign str.wrCtrl = doWrite && (awIdxQ == I_CTRL) && wStrb0Q;
  assign str.wrBits = wBitsQ;
  assign str.rdLow  = arHs && (arIdx == I_LOW);

  // R9: write response held under back-pressure
  assert_bvalid_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    bValid && !bReady |=> bValid);
  // R9: read data held stable under back-pressure
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    rValid && !rReady |=> rValid && $stable(rData));
  // R8: nothing new accepted while a write response is pending
  assert_no_accept_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    bValid |-> !awReady && !wReady);
  // R8: response follows once both halves are held
  assert_bvalid_after_both_R8: assert property (@(posedge clk) disable iff (!rstN)
    awHave && wHave && !bValid |=> bValid);
endmodule

// File: rtl/cycle_meter_axil.sv
module cycle_meter_axil
  import cyc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   awAddr,
  input  logic                awValid,
  output logic                awReady,
  input  logic [DATA_W-1:0]   wData,
  input  logic [DATA_W/8-1:0] wStrb,
  input  logic                wValid,
  output logic                wReady,
  output logic [1:0]          bResp,
  output logic                bValid,
  input  logic                bReady,
  input  logic [ADDR_W-1:0]   arAddr,
  input  logic                arValid,
  output logic                arReady,
  output logic [DATA_W-1:0]   rData,
  output logic [1:0]          rResp,
  output logic                rValid,
  input  logic                rReady
);
  cyc_strobe_t       str;
  logic [1:0]        ctrlBits;
  logic [DATA_W-1:0] cntLow;
  logic [DATA_W-1:0] cntHighShadow;

  cyc_axil_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .awAddr(awAddr), .awValid(awValid), .awReady(awReady),
    .wData(wData), .wStrb(wStrb), .wValid(wValid), .wReady(wReady),
    .bResp(bResp), .bValid(bValid), .bReady(bReady),
    .arAddr(arAddr), .arValid(arValid), .arReady(arReady),
    .rData(rData), .rResp(rResp), .rValid(rValid), .rReady(rReady),
    .ctrlBits(ctrlBits), .cntLow(cntLow), .cntHighShadow(cntHighShadow),
    .str(str)
  );

  cyc_counter_core #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_core (
    .clk(clk), .rstN(rstN), .str(str),
    .ctrlBits(ctrlBits), .cntLow(cntLow), .cntHighShadow(cntHighShadow)
  );
endmodule

// File: tb/cycle_meter_axil_tb.sv
module cycle_meter_axil_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  awAddr = '0;
  logic        awValid = 1'b0;
  logic        awReady;
  logic [31:0] wData = '0;
  logic [3:0]  wStrb = '0;
  logic        wValid = 1'b0;
  logic        wReady;
  logic [1:0]  bResp;
  logic        bValid;
  logic        bReady = 1'b0;
  logic [3:0]  arAddr = '0;
  logic        arValid = 1'b0;
  logic        arReady;
  logic [31:0] rData;
  logic [1:0]  rResp;
  logic        rValid;
  logic        rReady = 1'b0;

  always #5 clk = ~clk;

  cycle_meter_axil u_dut (
    .clk(clk), .rstN(rstN),
    .awAddr(awAddr), .awValid(awValid), .awReady(awReady),
    .wData(wData), .wStrb(wStrb), .wValid(wValid), .wReady(wReady),
    .bResp(bResp), .bValid(bValid), .bReady(bReady),
    .arAddr(arAddr), .arValid(arValid), .arReady(arReady),
    .rData(rData), .rResp(rResp), .rValid(rValid), .rReady(rReady)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // behavioural reference state
  logic [63:0] mCnt = '0;
  bit          mRun = 0;
  logic [1:0]  mCtrl = '0;
  logic [31:0] mShadow = '0;
  logic [3:0]  pendAddr = '0;
  logic [31:0] pendData = '0;
  logic [3:0]  pendStrb = '0;
  bit          prevB = 0;

  // Model advances just after each edge (R1..R4, R8: control applies on BVALID edge)
  always begin
    @(posedge clk);
    #1;
    if (!rstN) begin
      mCnt = '0; mRun = 0; mCtrl = '0; mShadow = '0; prevB = 0;
    end else begin
      if (bValid && !prevB && pendAddr[3:2] == 2'd0 && pendStrb[0]) begin
        if (pendData[1]) begin
          if (mRun) mCnt = mCnt + 1;
          mRun = 0;
        end else if (pendData[0] && !mCtrl[0]) begin
          mCnt = '0;
          mRun = 1;
        end else if (mRun) begin
          mCnt = mCnt + 1;
        end
        mCtrl = pendData[1:0];
      end else if (mRun) begin
        mCnt = mCnt + 1;
      end
      prevB = bValid;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic axiWrite(logic [3:0] a, logic [31:0] d, logic [3:0] s,
                          int gap, int bDelay, string req);
    bit awDone = 0, wDone = 0, willAw, willW;
    int cyc = 0;
    pendAddr = a; pendData = d; pendStrb = s;
    awAddr = a; wData = d; wStrb = s;
    @(negedge clk);
    forever begin
      awValid = !awDone && (gap >= 0 || cyc >= -gap);
      wValid  = !wDone && (gap <= 0 || cyc >= gap);
      willAw = awValid && awReady;
      willW  = wValid && wReady;
      @(negedge clk);
      cyc++;
      if (willAw) awDone = 1;
      if (willW)  wDone = 1;
      awValid = 1'b0; wValid = 1'b0;
      if (awDone && wDone) break;
    end
    check({req, "/R8 bvalid low one cycle after handshake"}, 32'(bValid), 32'd0);
    @(negedge clk);
    check({req, "/R8 bvalid after two edges"}, 32'(bValid), 32'd1);
    check({req, "/R7 bresp okay"}, 32'(bResp), 32'd0);
    for (int i = 0; i < bDelay; i++) begin
      @(negedge clk);
      check({req, "/R9 bvalid held"}, 32'(bValid), 32'd1);
      check({req, "/R8 no accept while busy"}, 32'({awReady, wReady}), 32'd0);
    end
    bReady = 1'b1;
    @(negedge clk);
    bReady = 1'b0;
    check({req, "/R9 bvalid drops after bready"}, 32'(bValid), 32'd0);
  endtask

  task automatic axiRead(logic [3:0] a, int rDelay, string req, output logic [31:0] got);
    logic [31:0] exp;
    case (a[3:2])
      2'd0: exp = {30'd0, mCtrl};
      2'd1: begin exp = mCnt[31:0]; mShadow = mCnt[63:32]; end
      2'd2: exp = mShadow;
      default: exp = '0;
    endcase
    arAddr = a; arValid = 1'b1;
    @(negedge clk);
    arValid = 1'b0;
    check({req, " rvalid"}, 32'(rValid), 32'd1);
    check({req, " rdata"}, rData, exp);
    check({req, "/R7 rresp okay"}, 32'(rResp), 32'd0);
    for (int i = 0; i < rDelay; i++) begin
      @(negedge clk);
      check({req, "/R9 rvalid held"}, 32'(rValid), 32'd1);
      check({req, "/R9 rdata held"}, rData, exp);
    end
    got = rData;
    rReady = 1'b1;
    @(negedge clk);
    rReady = 1'b0;
    check({req, "/R9 rvalid drops"}, 32'(rValid), 32'd0);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v1, v2;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 no pending response", 32'({bValid, rValid}), 32'd0);
    axiRead(4'h0, 0, "R10 ctrl after reset", v1);
    axiRead(4'h4, 0, "R10 count after reset", v1);
    axiRead(4'h8, 0, "R10 shadow after reset", v1);

    axiWrite(4'h0, 32'h1, 4'hF, 0, 0, "R2 start");
    idle(20);
    axiRead(4'h4, 0, "R1 running count", v1);
    axiRead(4'h8, 0, "R6 high shadow", v1);
    axiRead(4'h4, 2, "R1 count after delay", v1);

    axiWrite(4'h4, 32'hDEAD, 4'hF, 2, 3, "R7 write low ignored");
    axiRead(4'h4, 0, "R7 count unaffected", v1);

    axiWrite(4'h0, 32'h2, 4'hF, 0, 0, "R3 stop");
    idle(10);
    axiRead(4'h4, 0, "R3 frozen a", v1);
    idle(7);
    axiRead(4'h4, 0, "R3 frozen b", v2);
    check("R3 frozen value equal", v2, v1);
    axiRead(4'h0, 0, "R5 ctrl readback stop", v1);

    axiWrite(4'h0, 32'h1, 4'hF, 0, 0, "R2 restart clears");
    axiRead(4'h4, 0, "R2 small count after clear", v1);
    idle(5);
    axiWrite(4'h0, 32'h1, 4'hF, -3, 1, "R2 repeat start no clear");
    axiRead(4'h4, 0, "R2 continues", v1);

    axiWrite(4'h0, 32'h3, 4'hF, 1, 0, "R4 both set");
    axiRead(4'h0, 0, "R4 ctrl reads 3", v1);
    axiRead(4'h4, 0, "R4 frozen a", v1);
    idle(6);
    axiRead(4'h4, 0, "R4 frozen b", v2);
    check("R4 not running", v2, v1);

    axiWrite(4'h0, 32'h0, 4'h0, 0, 0, "R5 masked strobe");
    axiRead(4'h0, 0, "R5 ctrl unchanged", v1);
    axiWrite(4'hC, 32'h1, 4'hF, 0, 0, "R7 unmapped write");
    axiRead(4'hC, 0, "R7 unmapped reads zero", v1);
    axiRead(4'h0, 0, "R7 ctrl unchanged", v1);
    axiWrite(4'h8, 32'h5, 4'hF, 0, 0, "R7 write high ignored");
    axiRead(4'h8, 0, "R7 shadow unchanged", v1);

    axiWrite(4'h0, 32'h0, 4'hF, 0, 0, "R5 clear ctrl");
    axiWrite(4'h0, 32'h1, 4'hF, 0, 2, "R2 start again");
    idle(33);
    axiRead(4'h4, 4, "R1 long run", v1);
    axiRead(4'h8, 0, "R6 shadow matches", v1);
    axiRead(4'h4, 0, "R1 final", v1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule